// File: doc/BRIEF.md
# Three-Channel Output Compare Timer

This block is a 16-bit up-counter with three compare channels. The counter advances by one on every cycle where the count strobe `cnt_tick` is high and the timer is running. Each channel compares the count with its own compare register. On a match, the channel sets a sticky flag and changes its output level according to a 3-bit action code. Channel 0 can also act as the period register: when clear-on-match is enabled, the counter wraps to zero after it reaches that value. A stop-on-match mode halts the timer at the end of the period.

A small controller with three states sets how the output levels behave:

- **IDLE**: the state after reset. The timer has not been started yet, and each channel level follows its programmed initial level.
- **RUN**: the counter advances and matches take effect.
- **HALT**: the timer was stopped after running. The count and every level are frozen.

The state changes as follows:

- **IDLE→RUN** (start): a control write with the run bit set.
- **RUN→HALT** (pause): a control write with the run bit clear, or a channel 0 match while stop-on-match is enabled (period stop).
- **HALT→RUN** (resume): a control write with the run bit set.
- **IDLE** with a run-bit-clear write stays in IDLE.
- If a control write and a period stop fall in the same cycle, the write wins.

Software reaches the block through a synchronous write port (`wr_en`, `addr`, `wdata`). Read data is registered.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, the state is IDLE, and `pin_out`, `pin_oe` and `flag` are all zero.
- R2: In RUN, each cycle with `cnt_tick` high raises the count by one. Without `cnt_tick`, or outside RUN, the count does not move.
- R3: With clear-on-match (CTRL bit 1) set, a counted cycle at which count equals compare 0 loads zero, so one period lasts compare 0 value + 1 counted cycles.
- R4: With stop-on-match (CTRL bit 2) set, a counted match on channel 0 holds the count at the compare 0 value, moves to HALT, and the run bit then reads 0. With it clear, counting goes on past the match; if clear-on-match is also clear, the count continues to compare 0 value + 1.
- R5: Writing CTRL with bit 0 = 0 in RUN freezes the count and all channel levels. Writing bit 0 = 1 resumes counting from the frozen value.
- R6: In IDLE, each channel level takes its initial-level bit (OUTCFG bit i, 1 = high) at every clock edge and keeps that level until its first match in RUN.
- R7: A match is a counted cycle where count equals the channel's compare register. At the next edge the level changes by the channel's action code (ACTION bits 4i+2..4i):
  - 001 drives the level low.
  - 010 drives it high.
  - 011 inverts it.
  - 000 and 1xx leave it unchanged.
- R8: A match sets FLAGS bit i at the next edge. The flag stays set until a FLAGS write with bit i = 0. Writing 1 has no effect. A match in the same cycle as a clearing write leaves the flag set.
- R9: `pin_oe[i]` equals the enable bit OUTCFG bit 8+i. While that bit is 0, `pin_out[i]` is 0; while it is 1, `pin_out[i]` is the channel level.
- R10: Address map:
  - 0 CTRL: bit 0 run (reads 1 only in RUN), bit 1 clear-on-match, bit 2 stop-on-match.
  - 1 OUTCFG.
  - 2 ACTION.
  - 3 FLAGS.
  - 4 COUNT.
  - 5+i compare i.
  `rdata` shows the register selected by `addr` one clock after `addr` is applied.
- R11: A COUNT write loads the counter and takes priority over counting and over the clear on match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| cnt_tick | input | 1 | Count-enable strobe |
| rdata | output | 16 | Registered read data |
| pin_out | output | 3 | Channel output levels, gated by enable |
| pin_oe | output | 3 | Channel output enables |
| flag | output | 3 | Sticky match flags |

## Verification
A wrong controller state shows at the ports within one clock:
- A stuck RUN keeps the count moving, which `rdata` shows on the next COUNT read.
- A missed IDLE keeps `pin_out` from following a newly written initial level on the following edge.
- A spurious HALT leaves `pin_out` unchanged at the next match.

A wrong count or compare decision shows as a missing or misplaced flag bit and output edge on the cycle right after the intended match, so the per-clock comparison against the reference model points to the exact cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL   = 3'd0;
    localparam logic [AW-1:0] A_OUTCFG = 3'd1;
    localparam logic [AW-1:0] A_ACTION = 3'd2;
    localparam logic [AW-1:0] A_FLAGS  = 3'd3;
    localparam logic [AW-1:0] A_COUNT  = 3'd4;
    localparam int            CMP_BASE = 5;

    localparam int ACT_STRIDE = 4;
    localparam int OE_BASE    = 8;

    localparam logic [2:0] ACT_HOLD   = 3'b000;
    localparam logic [2:0] ACT_LOW    = 3'b001;
    localparam logic [2:0] ACT_HIGH   = 3'b010;
    localparam logic [2:0] ACT_TOGGLE = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  tmr_state_e        state,
    input  logic [DW-1:0]     cnt,
    input  logic [NCH-1:0]    flag,
    output logic              clr_en,
    output logic              stop_en,
    output logic [NCH-1:0]    init_lvl,
    output logic [NCH-1:0]    oe,
    output logic [3*NCH-1:0]  act,
    output logic [NCH*DW-1:0] cmp,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] rd_n;

    // control, output configuration and action codes
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_en   <= 1'b0;
            stop_en  <= 1'b0;
            init_lvl <= '0;
            oe       <= '0;
            act      <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    clr_en  <= wdata[1];
                    stop_en <= wdata[2];
                end
                A_OUTCFG: begin
                    init_lvl <= wdata[NCH-1:0];
                    oe       <= wdata[OE_BASE +: NCH];
                end
                A_ACTION: begin
                    for (int i = 0; i < NCH; i++) begin
                        act[3*i +: 3] <= wdata[ACT_STRIDE*i +: 3];
                    end
                end
                default: ;
            endcase
        end
    end

    // one compare register per channel
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[g*DW +: DW] <= '0;
            end else if (wr_en && addr == AW'(CMP_BASE + g)) begin
                cmp[g*DW +: DW] <= wdata;
            end
        end
    end

    always_comb begin
        rd_n = '0;
        unique case (addr)
            A_CTRL: begin
                rd_n[0] = (state == ST_RUN);
                rd_n[1] = clr_en;
                rd_n[2] = stop_en;
            end
            A_OUTCFG: begin
                rd_n[NCH-1:0]        = init_lvl;
                rd_n[OE_BASE +: NCH] = oe;
            end
            A_ACTION: begin
                for (int i = 0; i < NCH; i++) begin
                    rd_n[ACT_STRIDE*i +: 3] = act[3*i +: 3];
                end
            end
            A_FLAGS: rd_n[NCH-1:0] = flag;
            A_COUNT: rd_n = cnt;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == AW'(CMP_BASE + i)) rd_n = cmp[i*DW +: DW];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_n;
    end

endmodule

// File: rtl/cmp_timer_fsm.sv
module cmp_timer_fsm
    import cmp_timer_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run_wr,
    input  logic          run_val,
    input  logic          cnt_wr,
    input  logic [DW-1:0] cnt_wdata,
    input  logic          match_a,
    input  logic          clr_en,
    input  logic          stop_en,
    output tmr_state_e    state,
    output logic [DW-1:0] cnt,
    output logic          advance
);

    tmr_state_e state_d;
    logic       stop_hit;

    assign advance  = (state == ST_RUN) && tick;
    assign stop_hit = match_a && stop_en;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // transitions: start, pause, period stop, resume
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (run_wr && run_val) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (run_wr)        state_d = run_val ? ST_RUN : ST_HALT;
                else if (stop_hit) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (run_wr && run_val) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter: software load, hold on period stop, clear on period, step
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
        end else if (advance) begin
            if (stop_hit)                cnt <= cnt;
            else if (match_a && clr_en)  cnt <= '0;
            else                         cnt <= cnt + DW'(1);
        end
    end

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_state_e    state,
    input  logic          advance,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] cmp,
    input  logic [2:0]    act,
    input  logic          init_lvl,
    input  logic          oe,
    input  logic          flag_clr,
    output logic          hit,
    output logic          lvl,
    output logic          flag,
    output logic          pin_out,
    output logic          pin_oe
);

    assign hit = advance && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: lvl <= init_lvl;
                ST_RUN: begin
                    if (hit) begin
                        unique case (act)
                            ACT_LOW:    lvl <= 1'b0;
                            ACT_HIGH:   lvl <= 1'b1;
                            ACT_TOGGLE: lvl <= ~lvl;
                            default:    lvl <= lvl;
                        endcase
                    end
                end
                default: lvl <= lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~flag_clr) | hit;
    end

    assign pin_out = lvl & oe;
    assign pin_oe  = oe;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           cnt_tick,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] flag
);

    tmr_state_e        state_q;
    logic [DW-1:0]     cnt_q;
    logic              advance;
    logic              clr_en;
    logic              stop_en;
    logic [NCH-1:0]    init_lvl;
    logic [NCH-1:0]    oe;
    logic [3*NCH-1:0]  act_flat;
    logic [NCH*DW-1:0] cmp_flat;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    lvl;
    logic [NCH-1:0]    flag_clr;
    logic              run_wr;
    logic              cnt_wr;

    assign run_wr   = wr_en && (addr == A_CTRL);
    assign cnt_wr   = wr_en && (addr == A_COUNT);
    assign flag_clr = (wr_en && addr == A_FLAGS) ? ~wdata[NCH-1:0] : '0;

    cmp_timer_regs #(.DW(DW), .NCH(NCH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .state    (state_q),
        .cnt      (cnt_q),
        .flag     (flag),
        .clr_en   (clr_en),
        .stop_en  (stop_en),
        .init_lvl (init_lvl),
        .oe       (oe),
        .act      (act_flat),
        .cmp      (cmp_flat),
        .rdata    (rdata)
    );

    cmp_timer_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (cnt_tick),
        .run_wr    (run_wr),
        .run_val   (wdata[0]),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wdata),
        .match_a   (hit[0]),
        .clr_en    (clr_en),
        .stop_en   (stop_en),
        .state     (state_q),
        .cnt       (cnt_q),
        .advance   (advance)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmp_timer_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .state    (state_q),
            .advance  (advance),
            .cnt      (cnt_q),
            .cmp      (cmp_flat[g*DW +: DW]),
            .act      (act_flat[3*g +: 3]),
            .init_lvl (init_lvl[g]),
            .oe       (oe[g]),
            .flag_clr (flag_clr[g]),
            .hit      (hit[g]),
            .lvl      (lvl[g]),
            .flag     (flag[g]),
            .pin_out  (pin_out[g]),
            .pin_oe   (pin_oe[g])
        );
    end

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int DW  = 16,
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wdata,
    input logic           tick,
    input logic [1:0]     state,
    input logic [DW-1:0]  cnt,
    input logic [DW-1:0]  cmp_a,
    input logic           clr_en,
    input logic           stop_en,
    input logic [2:0]     act_a,
    input logic [NCH-1:0] lvl,
    input logic [NCH-1:0] flag
);

    logic run_now;
    logic hit_a;
    logic cnt_load;

    assign run_now  = (state == ST_RUN);
    assign hit_a    = run_now && tick && (cnt == cmp_a);
    assign cnt_load = wr_en && (addr == A_COUNT);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (run_now && tick && !hit_a && !wr_en) |=> (cnt == $past(cnt) + DW'(1)));

    // R3
    period_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_a && clr_en && !stop_en && !cnt_load) |=> (cnt == '0));

    // R4
    period_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_a && stop_en && !wr_en) |=> (state == ST_HALT && cnt == $past(cnt)));

    // R5
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_now && !cnt_load) |=> $stable(cnt));

    // R5
    halt_levels_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> $stable(lvl));

    // R7
    toggle_a_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_a && act_a == ACT_TOGGLE) |=> (lvl[0] != $past(lvl[0])));

    for (genvar g = 0; g < NCH; g++) begin : g_flag
        // R8
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flag[g] && !(wr_en && addr == A_FLAGS && !wdata[g])) |=> flag[g]);
    end

endmodule

bind cmp_timer cmp_timer_chk #(.DW(DW), .NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tick    (cnt_tick),
    .state   (state_q),
    .cnt     (cnt_q),
    .cmp_a   (cmp_flat[DW-1:0]),
    .clr_en  (clr_en),
    .stop_en (stop_en),
    .act_a   (act_flat[2:0]),
    .lvl     (lvl),
    .flag    (flag)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int NCH = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          cnt_tick = 1'b0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] pin_out, pin_oe, flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer #(.DW(DW), .NCH(NCH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_tick(cnt_tick), .rdata(rdata), .pin_out(pin_out),
        .pin_oe(pin_oe), .flag(flag)
    );

    function automatic void check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endfunction

    // behavioural reference model: 0 idle, 1 run, 2 halt
    int        m_state;
    bit        m_clr, m_stop, m_valid;
    bit [2:0]  m_init, m_oe, m_flag, m_lvl;
    bit [2:0]  m_act [3];
    bit [15:0] m_cnt, m_rd;
    bit [15:0] m_cmp [3];

    function automatic bit [15:0] m_read(bit [2:0] a);
        bit [15:0] v = 0;
        case (a)
            0: v = {13'd0, m_stop, m_clr, m_state == 1};
            1: v = {5'd0, m_oe, 5'd0, m_init};
            2: v = {5'd0, m_act[2], 1'b0, m_act[1], 1'b0, m_act[0]};
            3: v = {13'd0, m_flag};
            4: v = m_cnt;
            default: v = m_cmp[a - 5];
        endcase
        return v;
    endfunction

    always @(posedge clk) begin : model
        bit [2:0]  hit, nlvl, nflag;
        bit        adv, stop_hit;
        bit [15:0] ncnt;
        int        nstate;
        if (rst) begin
            m_state = 0; m_clr = 0; m_stop = 0; m_init = 0; m_oe = 0;
            m_flag = 0; m_lvl = 0; m_cnt = 0; m_rd = 0;
            for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_cmp[i] = 0; end
            m_valid = 1;
        end else begin
            m_rd = m_read(addr);
            adv = (m_state == 1) && cnt_tick;
            for (int i = 0; i < 3; i++) hit[i] = adv && (m_cnt == m_cmp[i]);
            stop_hit = hit[0] && m_stop;
            ncnt = m_cnt;
            if (wr_en && addr == 4)     ncnt = wdata;
            else if (adv) begin
                if (stop_hit)           ncnt = m_cnt;
                else if (hit[0] && m_clr) ncnt = 0;
                else                    ncnt = m_cnt + 1;
            end
            nstate = m_state;
            if (wr_en && addr == 0) begin
                if (wdata[0])          nstate = 1;
                else if (m_state != 0) nstate = 2;
            end else if (m_state == 1 && stop_hit) nstate = 2;
            nlvl = m_lvl;
            if (m_state == 0) nlvl = m_init;
            else if (m_state == 1) begin
                for (int i = 0; i < 3; i++) if (hit[i]) begin
                    case (m_act[i])
                        1: nlvl[i] = 0;
                        2: nlvl[i] = 1;
                        3: nlvl[i] = ~m_lvl[i];
                        default: ;
                    endcase
                end
            end
            nflag = m_flag;
            if (wr_en && addr == 3) nflag = nflag & wdata[2:0];
            nflag = nflag | hit;
            m_cnt = ncnt; m_state = nstate; m_lvl = nlvl; m_flag = nflag;
            if (wr_en) begin
                case (addr)
                    0: begin m_clr = wdata[1]; m_stop = wdata[2]; end
                    1: begin m_init = wdata[2:0]; m_oe = wdata[10:8]; end
                    2: for (int i = 0; i < 3; i++) m_act[i] = wdata[4*i +: 3];
                    5, 6, 7: m_cmp[addr - 5] = wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (m_valid) begin
            check("R10 rdata", rdata, m_rd);
            check(m_state == 0 ? "R6 levels" : "R7 levels", pin_out, m_lvl & m_oe);
            check("R9 enables", pin_oe, m_oe);
            check("R8 flags", flag, m_flag);
        end
    end

    task automatic wr(input bit [2:0] a, input bit [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit [2:0] a, output bit [15:0] v);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin : stim
        bit [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 flag", flag, 0);
        rd(0, v); check("R1 ctrl", v, 0);
        rd(4, v); check("R1 count", v, 0);

        wr(5, 5); wr(6, 2); wr(7, 4);
        wr(2, 16'h0123);              // ch0 toggle, ch1 high, ch2 low
        wr(1, 16'h0704);              // ch2 initial high, all enabled
        @(negedge clk);
        check("R6 initial level", pin_out, 3'b100);

        wr(0, 16'h0003);              // start, clear on period
        ticks(5);
        rd(4, v); check("R2 count after five ticks", v, 5);
        check("R7 high/low actions", pin_out, 3'b010);
        ticks(1);
        rd(4, v); check("R3 wrap to zero", v, 0);
        check("R7 toggle", pin_out, 3'b011);
        rd(3, v); check("R8 all flags set", v, 7);
        wr(3, 16'h0006);
        rd(3, v); check("R8 clear by zero", v, 6);
        wr(3, 16'h0007);
        rd(3, v); check("R8 write one ignored", v, 6);

        wr(0, 16'h0002);              // pause
        ticks(3);
        rd(4, v); check("R5 frozen count", v, 0);
        check("R5 frozen levels", pin_out, 3'b011);
        rd(0, v); check("R10 ctrl run cleared", v, 3'b010);
        wr(0, 16'h0003);
        ticks(2);
        rd(4, v); check("R5 resume", v, 2);

        @(negedge clk);               // R11 load while counting
        cnt_tick = 1'b1; wr_en = 1'b1; addr = 4; wdata = 3;
        @(negedge clk);
        cnt_tick = 1'b0; wr_en = 1'b0;
        rd(4, v); check("R11 load wins", v, 3);

        wr(0, 16'h0007);              // stop on period
        ticks(4);
        rd(4, v); check("R4 held at period", v, 5);
        rd(0, v); check("R4 run bit cleared", v, 3'b110);
        check("R4 toggle at stop", pin_out, 3'b010);
        wr(0, 16'h0001);              // run on, no clear, no stop
        ticks(3);
        rd(4, v); check("R4 continue past period", v, 8);

        wr(1, 16'h0004);
        check("R9 disabled enable", pin_oe, 0);
        check("R9 disabled pin", pin_out, 0);
        wr(1, 16'h0704);

        wr(2, 16'h0050);              // ch0 000, ch1 101, ch2 000
        wr(4, 0);
        ticks(6);
        check("R7 hold codes", pin_out, 3'b011);

        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            cnt_tick = ($urandom % 4) != 0;
            wr_en    = ($urandom % 5) == 0;
            addr     = 3'($urandom % 8);
            wdata    = 16'($urandom) & ((addr >= 4) ? 16'h000f : 16'h0fff);
        end
        @(negedge clk);
        wr_en = 1'b0; cnt_tick = 1'b0;
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule